// File: doc/BRIEF.md
# Compact float immediate loader

This block produces 64-bit floating-point register values from 16-bit immediates, so that common constants need no memory access. It has two operations. A load treats the immediate as the upper half of a single-precision word with a zero lower half. That is the same as reading it as a brain-float value. The word is then widened to double precision. A splice is a read-modify-write. It narrows the current double held in the target register to single precision, overwrites the lower 16 bits of that single word with the immediate, and widens the result again. A load followed by a splice therefore yields any single-precision constant, stored in double format.

The immediate reaches the block as three instruction fields, which the block assembles itself. Requests enter on a valid/ready channel. The result leaves on a valid/ready channel whose valid acts as the register write enable. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output stage is empty, or the output stage is being drained in the same cycle (`res_ready` high). A result that is not taken stays unchanged until it is taken. No floating-point status is read or changed. Instruction decode and the register file sit outside the block.

Top module: `fimm_builder`

## Requirements
- R1: A load (`req_op` = 0) forms the single word {imm, 16'h0000} and widens it to double: the sign is copied, a normal exponent is rebiased by adding 896, and the 23-bit fraction is placed at the top of the 52-bit fraction with zeros below. Immediate 0x3F80 gives 0x3FF0_0000_0000_0000, 0xBFC0 gives 0xBFF8_0000_0000_0000 and 0x3FFF gives 0x3FFF_E000_0000_0000.
- R2: The 16-bit immediate is {`imm_hi`, `imm_mid`, `imm_lo`}, with `imm_hi` most significant and `imm_lo` as bit 0.
- R3: Special values widen exactly. Immediate 0x0000 gives +0.0. 0x8000 gives 0x8000_0000_0000_0000. 0x7F80 gives 0x7FF0_0000_0000_0000. 0xFF80 gives 0xFFF0_0000_0000_0000. 0x7FC0 gives the quiet NaN 0x7FF8_0000_0000_0000. An all-ones single exponent always maps to an all-ones double exponent, with the fraction carried over.
- R4: A subnormal single word is widened to a normal double. Immediate 0x0040 gives 0x3800_0000_0000_0000, and 0x0001 gives 0x37A0_0000_0000_0000.
- R5: A splice (`req_op` = 1) narrows `req_reg` to a single word, replaces bits 15:0 of that word with the immediate, and widens the result as in R1, R3 and R4. A load of 0x3F80 followed by a splice of 0x8000 gives 0x3FF0_1000_0000_0000.
- R6: Narrowing keeps the sign. For a double exponent in 897..1150 it subtracts 896 from the exponent and keeps fraction bits 51:29, without rounding. Lower fraction bits of `req_reg` have no effect. Source 0x3FF0_0000_FFFF_FFFF spliced with 0x0000 gives 0x3FF0_0000_0000_0000.
- R7: Narrowing of values outside the normal single range works as follows. A double exponent of 2047 gives exponent 255 with fraction bits 51:29. An exponent in 874..896 gives a subnormal single whose fraction is {1, bits 51:29} shifted right by (897 - exponent), truncated. An exponent in 1151..2046 gives exponent 255 with a zero fraction. An exponent of 873 or below gives a signed zero. Examples: 0x37A0_0000_0000_0000 spliced with 0x0003 gives 0x37A0_0030_0000_0000; 0x47F0_0000_0000_0000 spliced with 0x0000 gives 0x7FF0_0000_0000_0000; 0x0010_0000_0000_0000 spliced with 0x0005 gives 0x36C4_0000_0000_0000.
- R8: A request accepted at a clock edge shows its result on `res_data` with `res_valid` high straight after that edge. `req_ready` equals (not `res_valid`) or `res_ready`. While `res_valid` is high and `res_ready` is low, `res_valid` and `res_data` stay unchanged. If a result is taken and no new request is accepted, `res_valid` drops.
- R9: While `rst_n` is low and after reset, `res_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 1 | 0 = load, 1 = splice |
| imm_hi | input | 10 | Immediate bits 15:6 |
| imm_mid | input | 5 | Immediate bits 5:1 |
| imm_lo | input | 1 | Immediate bit 0 |
| req_reg | input | 64 | Current double value of the target register (used by splice) |
| res_valid | output | 1 | Result present; register write enable |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_data | output | 64 | Double result to write |

## Verification
Each result is due exactly one edge after its request is accepted, and it then holds for as long as `res_ready` stays low. The bench keeps a behavioural model that applies the acceptance rule of R8 to the driven inputs. It computes the expected double with real arithmetic rather than bit manipulation. Model and ports are compared on every falling edge, half a cycle after the registers update. Directed cases release a request, wait for the next falling edge after acceptance, and compare against the literal patterns listed in the requirements. Random traffic with a toggling `res_ready` exercises stalls.

// File: rtl/fimm_pkg.sv
package fimm_pkg;
  localparam int SP_W      = 32;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int DP_W      = 64;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;
  localparam int FRAC_PAD  = DP_FRAC_W - SP_FRAC_W;          // 29
  localparam int BIAS_GAP  = 1023 - 127;                      // 896
  localparam int HALF_W    = SP_W / 2;                        // 16
  // double exponent window that narrows to a normal single
  localparam int NORM_LO   = BIAS_GAP + 1;                    // 897
  localparam int NORM_HI   = BIAS_GAP + 254;                  // 1150
  // lowest double exponent that still leaves a nonzero subnormal single
  localparam int SUB_LO    = NORM_LO - SP_FRAC_W;             // 874

  typedef enum logic {
    OP_LOAD   = 1'b0,
    OP_SPLICE = 1'b1
  } fimm_op_e;

  typedef struct packed {
    logic                 sign;
    logic [SP_EXP_W-1:0]  exp;
    logic [SP_FRAC_W-1:0] frac;
  } sp_word_t;

  typedef struct packed {
    logic                 sign;
    logic [DP_EXP_W-1:0]  exp;
    logic [DP_FRAC_W-1:0] frac;
  } dp_word_t;
endpackage

// File: rtl/fimm_gather.sv
module fimm_gather #(
  parameter int HI_W  = 10,
  parameter int MID_W = 5,
  parameter int LO_W  = 1,
  localparam int IMM_W = HI_W + MID_W + LO_W
) (
  input  logic [HI_W-1:0]  f_hi,
  input  logic [MID_W-1:0] f_mid,
  input  logic [LO_W-1:0]  f_lo,
  output logic [IMM_W-1:0] imm
);
  // high field first, single low field last
  assign imm = {f_hi, f_mid, f_lo};
endmodule

// File: rtl/fimm_narrow.sv
module fimm_narrow
  import fimm_pkg::*;
(
  input  dp_word_t dbl,
  output sp_word_t sgl
);
  localparam int SH_W = $clog2(SP_FRAC_W + 1);

  logic [SP_FRAC_W-1:0] top_frac;
  logic [SP_FRAC_W:0]   lead_mant;
  logic [SP_FRAC_W:0]   denorm;
  logic [DP_EXP_W-1:0]  rebased;
  logic [DP_EXP_W-1:0]  sh_full;
  logic [SH_W-1:0]      sh;

  assign top_frac  = dbl.frac[DP_FRAC_W-1 -: SP_FRAC_W];
  assign lead_mant = {1'b1, top_frac};
  assign rebased   = dbl.exp - DP_EXP_W'(BIAS_GAP);
  assign sh_full   = DP_EXP_W'(NORM_LO) - dbl.exp;
  assign sh        = sh_full[SH_W-1:0];
  assign denorm    = lead_mant >> sh;

  always_comb begin
    sgl.sign = dbl.sign;
    if (&dbl.exp) begin
      sgl.exp  = '1;
      sgl.frac = top_frac;
    end else if (dbl.exp >= DP_EXP_W'(NORM_LO) && dbl.exp <= DP_EXP_W'(NORM_HI)) begin
      sgl.exp  = rebased[SP_EXP_W-1:0];
      sgl.frac = top_frac;
    end else if (dbl.exp > DP_EXP_W'(NORM_HI)) begin
      sgl.exp  = '1;
      sgl.frac = '0;
    end else if (dbl.exp >= DP_EXP_W'(SUB_LO)) begin
      sgl.exp  = '0;
      sgl.frac = denorm[SP_FRAC_W-1:0];
    end else begin
      sgl.exp  = '0;
      sgl.frac = '0;
    end
  end
endmodule

// File: rtl/fimm_widen.sv
module fimm_widen
  import fimm_pkg::*;
(
  input  sp_word_t sgl,
  output dp_word_t dbl
);
  localparam int POS_W = $clog2(SP_FRAC_W + 1);

  logic [POS_W-1:0]     lead;
  logic [SP_FRAC_W:0]   shifted;
  logic [POS_W-1:0]     lshift;
  logic [DP_EXP_W-1:0]  sub_exp;
  logic [DP_EXP_W-1:0]  norm_exp;

  // position of the highest set fraction bit
  always_comb begin
    lead = '0;
    for (int i = 0; i < SP_FRAC_W; i++) begin
      if (sgl.frac[i]) lead = POS_W'(i);
    end
  end

  assign lshift   = POS_W'(SP_FRAC_W) - lead;
  assign shifted  = {1'b0, sgl.frac} << lshift;
  assign sub_exp  = DP_EXP_W'(lead) + DP_EXP_W'(SUB_LO);
  assign norm_exp = DP_EXP_W'(sgl.exp) + DP_EXP_W'(BIAS_GAP);

  always_comb begin
    dbl.sign = sgl.sign;
    if (&sgl.exp) begin
      dbl.exp  = '1;
      dbl.frac = {sgl.frac, {FRAC_PAD{1'b0}}};
    end else if (sgl.exp == '0 && sgl.frac == '0) begin
      dbl.exp  = '0;
      dbl.frac = '0;
    end else if (sgl.exp == '0) begin
      dbl.exp  = sub_exp;
      dbl.frac = {shifted[SP_FRAC_W-1:0], {FRAC_PAD{1'b0}}};
    end else begin
      dbl.exp  = norm_exp;
      dbl.frac = {sgl.frac, {FRAC_PAD{1'b0}}};
    end
  end
endmodule

// File: rtl/fimm_builder.sv
module fimm_builder
  import fimm_pkg::*;
#(
  parameter int HI_W  = 10,
  parameter int MID_W = 5,
  parameter int LO_W  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_op,
  input  logic [HI_W-1:0]    imm_hi,
  input  logic [MID_W-1:0]   imm_mid,
  input  logic [LO_W-1:0]    imm_lo,
  input  logic [DP_W-1:0]    req_reg,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [DP_W-1:0]    res_data
);
  localparam int IMM_W = HI_W + MID_W + LO_W;

  logic [IMM_W-1:0] imm;
  sp_word_t         narrowed;
  sp_word_t         staged;
  dp_word_t         widened;
  dp_word_t         src_dbl;
  logic             accept;
  logic             out_vld_q;
  logic [DP_W-1:0]  out_data_q;

  fimm_gather #(.HI_W(HI_W), .MID_W(MID_W), .LO_W(LO_W)) u_gather (
    .f_hi (imm_hi),
    .f_mid(imm_mid),
    .f_lo (imm_lo),
    .imm  (imm)
  );

  assign src_dbl = dp_word_t'(req_reg);

  fimm_narrow u_narrow (
    .dbl(src_dbl),
    .sgl(narrowed)
  );

  always_comb begin
    if (fimm_op_e'(req_op) == OP_SPLICE)
      staged = sp_word_t'({narrowed[SP_W-1:HALF_W], imm[HALF_W-1:0]});
    else
      staged = sp_word_t'({imm[HALF_W-1:0], {HALF_W{1'b0}}});
  end

  fimm_widen u_widen (
    .sgl(staged),
    .dbl(widened)
  );

  assign req_ready = !out_vld_q || res_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld_q  <= 1'b0;
      out_data_q <= '0;
    end else if (accept) begin
      out_vld_q  <= 1'b1;
      out_data_q <= widened;
    end else if (res_ready) begin
      out_vld_q  <= 1'b0;
    end
  end

  assign res_valid = out_vld_q;
  assign res_data  = out_data_q;
endmodule

// File: rtl/fimm_checker.sv
module fimm_checker #(
  parameter int HI_W  = 10,
  parameter int MID_W = 5,
  parameter int LO_W  = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_op,
  input logic [HI_W-1:0]  imm_hi,
  input logic [MID_W-1:0] imm_mid,
  input logic [LO_W-1:0]  imm_lo,
  input logic             res_valid,
  input logic             res_ready,
  input logic [63:0]      res_data
);
  logic [HI_W+MID_W+LO_W-1:0] imm_cat;
  logic                       took;
  assign imm_cat = {imm_hi, imm_mid, imm_lo};
  assign took    = req_valid && req_ready;

  a_r8_result_next: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> res_valid);

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  a_r8_drain_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!took && res_valid && res_ready) |=> !res_valid);

  a_r1_load_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (took && !req_op) |=> (res_data[28:0] == 29'd0));

  a_r3_pos_inf: assert property (@(posedge clk) disable iff (!rst_n)
    (took && !req_op && imm_cat == 16'h7F80) |=> (res_data == 64'h7FF0_0000_0000_0000));

  a_r9_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> req_ready);
endmodule

bind fimm_builder fimm_checker #(.HI_W(HI_W), .MID_W(MID_W), .LO_W(LO_W)) u_fimm_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_op   (req_op),
  .imm_hi   (imm_hi),
  .imm_mid  (imm_mid),
  .imm_lo   (imm_lo),
  .res_valid(res_valid),
  .res_ready(res_ready),
  .res_data (res_data)
);

// File: tb/fimm_builder_test.sv
module fimm_builder_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_op = 1'b0;
  logic [9:0]  imm_hi = '0;
  logic [4:0]  imm_mid = '0;
  logic [0:0]  imm_lo = '0;
  logic [63:0] req_reg = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [63:0] res_data;

  int checks = 0;
  int fails  = 0;
  bit reported = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fimm_builder uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .imm_hi(imm_hi), .imm_mid(imm_mid), .imm_lo(imm_lo),
    .req_reg(req_reg), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data)
  );

  // ---------- behavioural reference ----------
  function automatic logic [63:0] ref_widen(input logic [31:0] w);
    logic s; int e; int f; real mag; logic [63:0] b;
    s = w[31]; e = int'(w[30:23]); f = int'(w[22:0]);
    if (e == 255) return {s, 11'h7FF, w[22:0], 29'd0};
    if (e == 0 && f == 0) return {s, 63'd0};
    if (e == 0) mag = real'(f) * (2.0 ** (-149));
    else        mag = (real'(f) + 8388608.0) * (2.0 ** (e - 150));
    b = $realtobits(mag);
    return {s, b[62:0]};
  endfunction

  function automatic logic [31:0] ref_narrow(input logic [63:0] d);
    logic s; real mag; longint m;
    s = d[63];
    if (d[62:52] == 11'h7FF) return {s, 8'hFF, d[51:29]};
    if (d[62:52] == 11'h000) return {s, 31'd0};
    mag = $bitstoreal({1'b0, d[62:0]});
    if (mag >= 2.0 ** 128) return {s, 8'hFF, 23'd0};
    if (mag >= 2.0 ** (-126)) return {s, 8'(int'(d[62:52]) - 896), d[51:29]};
    m = longint'($floor(mag * (2.0 ** 149)));
    return {s, 8'h00, m[22:0]};
  endfunction

  function automatic logic [63:0] ref_result(input logic op, input logic [15:0] imm,
                                             input logic [63:0] src);
    logic [31:0] n;
    if (!op) return ref_widen({imm, 16'h0000});
    n = ref_narrow(src);
    return ref_widen({n[31:16], imm});
  endfunction

  logic        mdl_valid = 1'b0;
  logic [63:0] mdl_data  = '0;
  string       mdl_tag   = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdl_valid = 1'b0;
    end else if (req_valid && (!mdl_valid || res_ready)) begin
      mdl_valid = 1'b1;
      mdl_data  = ref_result(req_op, {imm_hi, imm_mid, imm_lo}, req_reg);
      mdl_tag   = req_op ? "R5" : "R1";
    end else if (res_ready) begin
      mdl_valid = 1'b0;
    end
  end

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model (R8 handshake, R1/R5 data)
  always @(negedge clk) begin
    if (rst_n && !reported) begin
      check64("R8", {63'd0, req_ready}, {63'd0, (!mdl_valid || res_ready)});
      check64("R8", {63'd0, res_valid}, {63'd0, mdl_valid});
      if (mdl_valid) check64(mdl_tag, res_data, mdl_data);
    end
  end

  // ---------- stimulus helpers ----------
  task automatic drive(input logic op, input logic [15:0] imm, input logic [63:0] src);
    req_op = op; imm_hi = imm[15:6]; imm_mid = imm[5:1]; imm_lo = imm[0];
    req_reg = src; req_valid = 1'b1;
  endtask

  // issue one request and return right after the edge that accepts it
  task automatic send(input logic op, input logic [15:0] imm, input logic [63:0] src);
    @(posedge clk); #1;
    drive(op, imm, src);
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic directed(input string tag, input logic op, input logic [15:0] imm,
                          input logic [63:0] src, input logic [63:0] exp);
    send(op, imm, src);
    @(negedge clk);
    check64(tag, {63'd0, res_valid}, 64'd1);
    check64(tag, res_data, exp);
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: state during reset
    check64("R9", {63'd0, res_valid}, 64'd0);
    check64("R9", {63'd0, req_ready}, 64'd1);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check64("R9", {63'd0, res_valid}, 64'd0);

    directed("R1", 1'b0, 16'h3F80, 64'h0, 64'h3FF0_0000_0000_0000);
    directed("R1", 1'b0, 16'hBFC0, 64'h0, 64'hBFF8_0000_0000_0000);
    directed("R2", 1'b0, 16'h3FFF, 64'h0, 64'h3FFF_E000_0000_0000);
    directed("R3", 1'b0, 16'h0000, 64'h0, 64'h0000_0000_0000_0000);
    directed("R3", 1'b0, 16'h8000, 64'h0, 64'h8000_0000_0000_0000);
    directed("R3", 1'b0, 16'h7F80, 64'h0, 64'h7FF0_0000_0000_0000);
    directed("R3", 1'b0, 16'hFF80, 64'h0, 64'hFFF0_0000_0000_0000);
    directed("R3", 1'b0, 16'h7FC0, 64'h0, 64'h7FF8_0000_0000_0000);
    directed("R4", 1'b0, 16'h0040, 64'h0, 64'h3800_0000_0000_0000);
    directed("R4", 1'b0, 16'h0001, 64'h0, 64'h37A0_0000_0000_0000);
    directed("R5", 1'b1, 16'h8000, 64'h3FF0_0000_0000_0000, 64'h3FF0_1000_0000_0000);
    directed("R6", 1'b1, 16'h0000, 64'h3FF0_0000_FFFF_FFFF, 64'h3FF0_0000_0000_0000);
    directed("R7", 1'b1, 16'h0003, 64'h37A0_0000_0000_0000, 64'h37A0_0030_0000_0000);
    directed("R7", 1'b1, 16'h0000, 64'h47F0_0000_0000_0000, 64'h7FF0_0000_0000_0000);
    directed("R7", 1'b1, 16'h0005, 64'h0010_0000_0000_0000, 64'h36C4_0000_0000_0000);

    // R8: stall holds data, then drains
    @(posedge clk); #1 res_ready = 1'b0;
    send(1'b0, 16'h4000, 64'h0);
    repeat (3) begin
      @(negedge clk);
      check64("R8", res_data, 64'h4000_0000_0000_0000);
      check64("R8", {63'd0, req_ready}, 64'd0);
    end
    @(posedge clk); #1 res_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    check64("R8", {63'd0, res_valid}, 64'd0);

    // random traffic with back-pressure, chained through previous results
    for (int n = 0; n < 3000; n++) begin
      @(posedge clk); #1;
      res_ready = ($urandom_range(0, 3) != 0);
      if (!req_valid || req_ready) begin
        if ($urandom_range(0, 2) != 0) begin
          logic [63:0] src;
          src = ($urandom_range(0, 1) != 0) ? res_data : {$urandom, $urandom};
          drive(1'($urandom_range(0, 1)), 16'($urandom), src);
        end else begin
          req_valid = 1'b0;
        end
      end
    end
    @(posedge clk); #1 req_valid = 1'b0; res_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    report();
  end
endmodule